// File: doc/BRIEF.md
# Programmable Video Timing Generator

The block produces the raster timing of one display pipe from its pixel clock. A pixel counter walks each line and a half-line counter walks each field, so the vertical period is written in half-lines; for progressive timing that value is twice the total line count. From the counter position the block decodes four independent horizontal/vertical sync pairs, one for each display interface that hangs off the pipe. It also decodes an active-video window flag and raises a field-start event at the first pixel of each top and bottom field.

Everything is set through a word-addressed register port with a combinational read path. Software sets the line length, the field length, the four sync sets and the window, enables the field interrupts, then restarts the counters. In master mode the counters run freely. In slave mode an external sync input pulls them back to the start of a top field. Interlaced field offsets are not produced: the top and bottom register copies select per field, and the fields alternate.

Top module: `raster_timing_gen`

## Requirements
- R1: The pixel position runs from 0 up to the line-clocks register (word 1, bits [15:0]) minus one. A half-line counter advances at pixel 0 and at pixel line-clocks/2, and wraps after the half-lines register (word 2, bits [15:0]) half-lines. The line number is half-line/2 + 1, so lines count from 1. The field flag starts as top after a restart and alternates top/bottom on every half-line wrap. While either register is zero the counters do not move.
- R2: Sync set k (k = 0..3) has its base at word 16 + 8k. Its horizontal register at offset 0 holds the assert pixel in [15:0] and the deassert pixel in [31:16]. hsync[k] is high when assert <= pixel < deassert.
- R3: The top vertical register (offset 1) and the bottom one (offset 2) hold the first line in [15:0] and the stop line in [31:16]. The top and bottom edge registers (offsets 3 and 4, bits [15:0]) give the pixel at which the vertical edge is taken. vsync[k] is high from (first line, edge pixel) inclusive to (stop line, edge pixel) exclusive, ordered by line and then by pixel, using the copy that matches the current field.
- R4: The window registers hold the line in [31:16] and the pixel in [15:0], at words 4 (top start), 5 (top stop), 6 (bottom start) and 7 (bottom stop). active is high when the line lies between start and stop line inclusive and the pixel lies between start and stop pixel inclusive, using the current field's copy.
- R5: Status (word 8) bit 1 is set on the clock edge that ends the first pixel (pixel 0, half-line 0) of a top field, and bit 0 on the one that ends the first pixel of a bottom field. An event and a clear of the same bit in the same cycle leave the bit set.
- R6: Writing ones to word 9 clears the matching status bits and leaves the other bits unchanged.
- R7: Writing ones to word 12 sets mask bits and writing ones to word 11 clears them; the mask is read at word 10 and no other bit moves. irq is the OR of the status bits whose mask bit is set.
- R8: A write to word 3 with bit 0 set restarts the counters on that clock edge: the next state is pixel 0, line 1, top field. A write with bit 0 clear has no effect.
- R9: Mode word 0, bit 0: 0 selects master operation, where ext_sync is ignored. 1 selects slave operation, where ext_sync high at a clock edge restarts the counters exactly as in R8.
- R10: After reset every register and the status and mask read zero, irq is low, and all sync outputs and the window flag are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_sync | input | 1 | External restart pulse, used in slave mode |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| hsync | output | N_SYNC | Horizontal sync per set |
| vsync | output | N_SYNC | Vertical sync per set |
| active | output | 1 | Active-video window flag |
| irq | output | 1 | Masked field interrupt |

## Verification
The hardest case to reach from the ports is a status clear that lands on the same edge as a field-start event. Both are rare events with a fixed phase, and the frame position is not visible at the ports. The bench gets there by writing the restart register, which places the counters at the first pixel of a top field on a known edge. It then times the clear write to commit on the very next edge, where the top event is registered, and checks that the top bit survives while the bottom bit is cleared. A bench-side frame position, derived from the programmed line and field lengths and reset by the same restart and slave pulses, then predicts every sync, window and interrupt value cycle by cycle.

// File: rtl/rtg_pkg.sv
// Shared widths, register word addresses and configuration records for the
// raster timing generator. Positions are 16 bits because every register
// packs two positions into one 32-bit word.
package rtg_pkg;
    localparam int POS_W  = 16;
    localparam int REG_W  = 2 * POS_W;
    localparam int ADDR_W = 6;
    localparam int IRQ_N  = 2;
    localparam int IRQ_BOT = 0;
    localparam int IRQ_TOP = 1;

    // Per-set register block layout
    localparam int SET_BASE   = 16;
    localparam int SET_STRIDE = 8;
    localparam int OFF_H      = 0;
    localparam int OFF_VT     = 1;
    localparam int OFF_VB     = 2;
    localparam int OFF_ET     = 3;
    localparam int OFF_EB     = 4;

    localparam logic [ADDR_W-1:0] A_MODE     = 6'd0;
    localparam logic [ADDR_W-1:0] A_CLKS     = 6'd1;
    localparam logic [ADDR_W-1:0] A_HALFLN   = 6'd2;
    localparam logic [ADDR_W-1:0] A_RESTART  = 6'd3;
    localparam logic [ADDR_W-1:0] A_WT_START = 6'd4;
    localparam logic [ADDR_W-1:0] A_WT_STOP  = 6'd5;
    localparam logic [ADDR_W-1:0] A_WB_START = 6'd6;
    localparam logic [ADDR_W-1:0] A_WB_STOP  = 6'd7;
    localparam logic [ADDR_W-1:0] A_STAT     = 6'd8;
    localparam logic [ADDR_W-1:0] A_STAT_CLR = 6'd9;
    localparam logic [ADDR_W-1:0] A_MASK     = 6'd10;
    localparam logic [ADDR_W-1:0] A_MASK_CLR = 6'd11;
    localparam logic [ADDR_W-1:0] A_MASK_SET = 6'd12;

    typedef logic [POS_W-1:0] pos_t;

    typedef enum logic {
        FLD_TOP = 1'b0,
        FLD_BOT = 1'b1
    } field_t;

    typedef struct packed {
        pos_t h_on;
        pos_t h_off;
        pos_t vt_first;
        pos_t vt_stop;
        pos_t vb_first;
        pos_t vb_stop;
        pos_t vt_edge;
        pos_t vb_edge;
    } sync_cfg_t;

    typedef struct packed {
        pos_t line_first;
        pos_t px_first;
        pos_t line_last;
        pos_t px_last;
    } win_cfg_t;
endpackage

// File: rtl/rtg_counter.sv
// Pixel and half-line counters with field parity.
// Assumes: the configuration may change at any time; the wrap compares use
// ">=" so a shortened line or field still wraps. The counters hold while
// either length register is zero. A restart wins over counting.
module rtg_counter
    import rtg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  pos_t   line_clks,
    input  pos_t   field_hl,
    input  logic   restart,
    output pos_t   px,
    output pos_t   line,
    output field_t fld,
    output logic   evt_top,
    output logic   evt_bot
);
    pos_t             hl_q;
    logic [POS_W:0]   px_inc;
    logic [POS_W:0]   hl_inc;
    logic             run;
    logic             line_end;
    logic             half_pt;
    logic             hl_adv;
    logic             field_end;
    logic             first_px;

    // Wrap and half-line decode from the current position
    always_comb begin
        run       = (line_clks != '0) && (field_hl != '0);
        px_inc    = {1'b0, px} + (POS_W+1)'(1);
        hl_inc    = {1'b0, hl_q} + (POS_W+1)'(1);
        line_end  = px_inc >= {1'b0, line_clks};
        half_pt   = px_inc == {2'b00, line_clks[POS_W-1:1]};
        hl_adv    = line_end || half_pt;
        field_end = hl_adv && (hl_inc >= {1'b0, field_hl});
    end

    // Counter state: restart, then free counting when configured
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px   <= '0;
            hl_q <= '0;
            fld  <= FLD_TOP;
        end else if (restart) begin
            px   <= '0;
            hl_q <= '0;
            fld  <= FLD_TOP;
        end else if (run) begin
            px <= line_end ? '0 : px_inc[POS_W-1:0];
            if (hl_adv) begin
                hl_q <= field_end ? '0 : hl_inc[POS_W-1:0];
            end
            if (field_end) begin
                fld <= (fld == FLD_TOP) ? FLD_BOT : FLD_TOP;
            end
        end
    end

    // Line number counts from 1; field-start events on the first pixel
    always_comb begin
        line     = (hl_q >> 1) + POS_W'(1);
        first_px = run && (px == '0) && (hl_q == '0);
        evt_top  = first_px && (fld == FLD_TOP);
        evt_bot  = first_px && (fld == FLD_BOT);
    end

    AST_PX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && line_end) |=> (px == '0)); // R1
    AST_FIELD_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart && field_end) |=> (fld != $past(fld))); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !restart) |=> ($stable(px) && $stable(hl_q))); // R1
    AST_RESTART_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (px == '0 && line == POS_W'(1) && fld == FLD_TOP)); // R8
endmodule

// File: rtl/rtg_sync_unit.sv
// One sync set: decodes a horizontal and a vertical sync from the position.
// Assumes: deassert positions lie after assert positions (no wrap through
// the end of a line or field); the vertical window is chosen by field.
module rtg_sync_unit
    import rtg_pkg::*;
(
    input  sync_cfg_t cfg,
    input  pos_t      px,
    input  pos_t      line,
    input  field_t    fld,
    output logic      hs,
    output logic      vs
);
    logic [2*POS_W-1:0] here;
    logic [2*POS_W-1:0] v_on;
    logic [2*POS_W-1:0] v_off;

    // Horizontal span within the line
    always_comb begin
        hs = (px >= cfg.h_on) && (px < cfg.h_off);
    end

    // Vertical span ordered by line, then by edge pixel within the line
    always_comb begin
        here  = {line, px};
        v_on  = (fld == FLD_BOT) ? {cfg.vb_first, cfg.vb_edge} : {cfg.vt_first, cfg.vt_edge};
        v_off = (fld == FLD_BOT) ? {cfg.vb_stop,  cfg.vb_edge} : {cfg.vt_stop,  cfg.vt_edge};
        vs    = (here >= v_on) && (here < v_off);
    end
endmodule

// File: rtl/rtg_window.sv
// Active-video window flag: inclusive line and pixel ranges, per field.
// Assumes: start <= stop on both axes for a non-empty window.
module rtg_window
    import rtg_pkg::*;
(
    input  win_cfg_t win_top,
    input  win_cfg_t win_bot,
    input  field_t   fld,
    input  pos_t     px,
    input  pos_t     line,
    output logic     active
);
    win_cfg_t w;

    // Pick the field copy and test both axes
    always_comb begin
        w      = (fld == FLD_BOT) ? win_bot : win_top;
        active = (line >= w.line_first) && (line <= w.line_last) &&
                 (px >= w.px_first) && (px <= w.px_last);
    end
endmodule

// File: rtl/rtg_regs.sv
// Register port: configuration storage, restart strobe, field-event status
// with write-one-to-clear, mask with separate set and clear words, and the
// masked interrupt. Reads are combinational; unmapped words read zero.
// Assumes: one register access per cycle.
module rtg_regs
    import rtg_pkg::*;
#(
    parameter int N_SYNC = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [REG_W-1:0]        wdata,
    output logic [REG_W-1:0]        rdata,
    input  logic                    evt_top,
    input  logic                    evt_bot,
    output logic                    slave,
    output pos_t                    line_clks,
    output pos_t                    field_hl,
    output logic                    restart,
    output win_cfg_t                win_top,
    output win_cfg_t                win_bot,
    output sync_cfg_t [N_SYNC-1:0]  sync_cfg,
    output logic                    irq
);
    logic [IRQ_N-1:0] stat_q;
    logic [IRQ_N-1:0] mask_q;
    logic [IRQ_N-1:0] stat_clr;
    logic [IRQ_N-1:0] mask_set;
    logic [IRQ_N-1:0] mask_clr;
    logic [IRQ_N-1:0] evt_vec;

    // Global configuration words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slave     <= 1'b0;
            line_clks <= '0;
            field_hl  <= '0;
            win_top   <= '0;
            win_bot   <= '0;
        end else if (wr) begin
            case (addr)
                A_MODE:     slave     <= wdata[0];
                A_CLKS:     line_clks <= wdata[POS_W-1:0];
                A_HALFLN:   field_hl  <= wdata[POS_W-1:0];
                A_WT_START: {win_top.line_first, win_top.px_first} <= wdata;
                A_WT_STOP:  {win_top.line_last,  win_top.px_last}  <= wdata;
                A_WB_START: {win_bot.line_first, win_bot.px_first} <= wdata;
                A_WB_STOP:  {win_bot.line_last,  win_bot.px_last}  <= wdata;
                default: ;
            endcase
        end
    end

    // One register block per sync set
    for (genvar k = 0; k < N_SYNC; k++) begin : g_set
        localparam logic [ADDR_W-1:0] A_H  = ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_H);
        localparam logic [ADDR_W-1:0] A_VT = ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_VT);
        localparam logic [ADDR_W-1:0] A_VB = ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_VB);
        localparam logic [ADDR_W-1:0] A_ET = ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_ET);
        localparam logic [ADDR_W-1:0] A_EB = ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_EB);
        sync_cfg_t set_q;

        // Store the set's words
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                set_q <= '0;
            end else if (wr) begin
                if (addr == A_H)  {set_q.h_off,   set_q.h_on}     <= wdata;
                if (addr == A_VT) {set_q.vt_stop, set_q.vt_first} <= wdata;
                if (addr == A_VB) {set_q.vb_stop, set_q.vb_first} <= wdata;
                if (addr == A_ET) set_q.vt_edge <= wdata[POS_W-1:0];
                if (addr == A_EB) set_q.vb_edge <= wdata[POS_W-1:0];
            end
        end
        assign sync_cfg[k] = set_q;
    end

    // Write strobes for restart, status clear and mask aliases
    always_comb begin
        restart  = wr && (addr == A_RESTART) && wdata[0];
        stat_clr = (wr && addr == A_STAT_CLR) ? wdata[IRQ_N-1:0] : '0;
        mask_set = (wr && addr == A_MASK_SET) ? wdata[IRQ_N-1:0] : '0;
        mask_clr = (wr && addr == A_MASK_CLR) ? wdata[IRQ_N-1:0] : '0;
        evt_vec           = '0;
        evt_vec[IRQ_BOT]  = evt_bot;
        evt_vec[IRQ_TOP]  = evt_top;
    end

    // Status and mask: a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | evt_vec;
            mask_q <= (mask_q & ~mask_clr) | mask_set;
        end
    end

    // Masked interrupt
    always_comb begin
        irq = |(stat_q & mask_q);
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_MODE:     rdata[0] = slave;
            A_CLKS:     rdata[POS_W-1:0] = line_clks;
            A_HALFLN:   rdata[POS_W-1:0] = field_hl;
            A_WT_START: rdata = {win_top.line_first, win_top.px_first};
            A_WT_STOP:  rdata = {win_top.line_last,  win_top.px_last};
            A_WB_START: rdata = {win_bot.line_first, win_bot.px_first};
            A_WB_STOP:  rdata = {win_bot.line_last,  win_bot.px_last};
            A_STAT:     rdata[IRQ_N-1:0] = stat_q;
            A_MASK:     rdata[IRQ_N-1:0] = mask_q;
            default: ;
        endcase
        for (int k = 0; k < N_SYNC; k++) begin
            if (addr == ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_H))  rdata = {sync_cfg[k].h_off,   sync_cfg[k].h_on};
            if (addr == ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_VT)) rdata = {sync_cfg[k].vt_stop, sync_cfg[k].vt_first};
            if (addr == ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_VB)) rdata = {sync_cfg[k].vb_stop, sync_cfg[k].vb_first};
            if (addr == ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_ET)) rdata = {{POS_W{1'b0}}, sync_cfg[k].vt_edge};
            if (addr == ADDR_W'(SET_BASE + SET_STRIDE*k + OFF_EB)) rdata = {{POS_W{1'b0}}, sync_cfg[k].vb_edge};
        end
    end

    AST_TOP_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_top |=> stat_q[IRQ_TOP]); // R5
    AST_BOT_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        evt_bot |=> stat_q[IRQ_BOT]); // R5
    AST_CLR_BOT: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr[IRQ_BOT] && !evt_bot) |=> !stat_q[IRQ_BOT]); // R6
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[IRQ_TOP] && !stat_clr[IRQ_TOP]) |=> stat_q[IRQ_TOP]); // R6
    AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (|mask_set) |=> ((mask_q & $past(mask_set)) == $past(mask_set))); // R7
    AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|mask_clr) |=> ((mask_q & $past(mask_clr)) == '0)); // R7
    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq); // R7
endmodule

// File: rtl/raster_timing_gen.sv
// Programmable video timing generator for one display pipe.
// Counts pixels per line and half-lines per field, and decodes N_SYNC sync
// pairs, an active-window flag and a masked field interrupt. In slave mode
// ext_sync restarts the counters. Outputs are decoded combinationally from
// the counter registers, with no added latency.
// Assumes: ext_sync is synchronous to clk; N_SYNC <= 6 (address map).
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int N_SYNC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_sync,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [N_SYNC-1:0] hsync,
    output logic [N_SYNC-1:0] vsync,
    output logic              active,
    output logic              irq
);
    logic                   slave;
    logic                   sw_restart;
    logic                   restart;
    pos_t                   line_clks;
    pos_t                   field_hl;
    pos_t                   px;
    pos_t                   line;
    field_t                 fld;
    logic                   evt_top;
    logic                   evt_bot;
    win_cfg_t               win_top;
    win_cfg_t               win_bot;
    sync_cfg_t [N_SYNC-1:0] sync_cfg;

    rtg_regs #(.N_SYNC(N_SYNC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .evt_top   (evt_top),
        .evt_bot   (evt_bot),
        .slave     (slave),
        .line_clks (line_clks),
        .field_hl  (field_hl),
        .restart   (sw_restart),
        .win_top   (win_top),
        .win_bot   (win_bot),
        .sync_cfg  (sync_cfg),
        .irq       (irq)
    );

    // Counter restart from software or, in slave mode, the external pulse
    always_comb begin
        restart = sw_restart || (slave && ext_sync);
    end

    rtg_counter u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clks (line_clks),
        .field_hl  (field_hl),
        .restart   (restart),
        .px        (px),
        .line      (line),
        .fld       (fld),
        .evt_top   (evt_top),
        .evt_bot   (evt_bot)
    );

    for (genvar k = 0; k < N_SYNC; k++) begin : g_sync
        rtg_sync_unit u_sync (
            .cfg  (sync_cfg[k]),
            .px   (px),
            .line (line),
            .fld  (fld),
            .hs   (hsync[k]),
            .vs   (vsync[k])
        );
    end

    rtg_window u_win (
        .win_top (win_top),
        .win_bot (win_bot),
        .fld     (fld),
        .px      (px),
        .line    (line),
        .active  (active)
    );

    AST_SLAVE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (slave && ext_sync) |=> (px == '0 && fld == FLD_TOP)); // R9
endmodule

// File: tb/raster_timing_gen_tb.sv
`timescale 1ns/1ps
module raster_timing_gen_tb;
    localparam int CLKS = 10;
    localparam int HL   = 8;
    localparam int FRAME2 = CLKS * HL;   // two fields
    localparam int FIELD  = FRAME2 / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_sync = 1'b0;
    logic        reg_wr = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  hsync;
    logic [3:0]  vsync;
    logic        active;
    logic        irq;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  tpos     = 0;
    bit  tb_slave = 1'b0;
    bit  done     = 1'b0;

    raster_timing_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_sync  (ext_sync),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .hsync     (hsync),
        .vsync     (vsync),
        .active    (active),
        .irq       (irq)
    );

    always #2.5 clk = ~clk;

    // Bench frame position from R8/R9: restart edges return it to zero
    always @(posedge clk) begin
        if (reg_wr && reg_addr == 6'd0) tb_slave <= reg_wdata[0];
        if ((reg_wr && reg_addr == 6'd3 && reg_wdata[0]) || (tb_slave && ext_sync))
            tpos <= 0;
        else
            tpos <= tpos + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic [5:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [5:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected outputs from the programmed configuration (see program_all)
    task automatic check_outputs();
        int tt = tpos % FRAME2;
        int px = tt % CLKS;
        int ln = (tt % FIELD) / CLKS + 1;
        bit bot = (tt >= FIELD);
        logic [3:0] ehs;
        logic [3:0] evs;
        logic ede;
        for (int k = 0; k < 4; k++) begin
            int here = ln * 1000 + px;
            int von  = bot ? (1000 + 9 - k) : (2000 + k);
            int voff = bot ? (2000 + 9 - k) : (3000 + k);
            ehs[k] = (px >= 1 + k) && (px < 4 + k);
            evs[k] = (here >= von) && (here < voff);
        end
        ede = bot ? (ln >= 1 && ln <= 4 && px <= 9)
                  : (ln >= 2 && ln <= 3 && px >= 2 && px <= 7);
        chk(hsync === ehs, "R2", "hsync", hsync, ehs);
        chk(vsync === evs, "R3", "vsync", vsync, evs);
        chk(active === ede, "R4", "active", active, ede);
    endtask

    task automatic program_all();
        write_reg(6'd1, CLKS);
        write_reg(6'd2, HL);
        for (int k = 0; k < 4; k++) begin
            write_reg(6'(16 + 8*k + 0), {16'(4 + k), 16'(1 + k)});
            write_reg(6'(16 + 8*k + 1), {16'd3, 16'd2});
            write_reg(6'(16 + 8*k + 2), {16'd2, 16'd1});
            write_reg(6'(16 + 8*k + 3), 32'(k));
            write_reg(6'(16 + 8*k + 4), 32'(9 - k));
        end
        write_reg(6'd4, {16'd2, 16'd2});
        write_reg(6'd5, {16'd3, 16'd7});
        write_reg(6'd6, {16'd1, 16'd0});
        write_reg(6'd7, {16'd4, 16'd9});
    endtask

    task automatic test_reset();
        logic [31:0] d;
        chk(hsync === 4'h0, "R10", "hsync after reset", hsync, 0);
        chk(vsync === 4'h0, "R10", "vsync after reset", vsync, 0);
        chk(active === 1'b0, "R10", "active after reset", active, 0);
        chk(irq === 1'b0, "R10", "irq after reset", irq, 0);
        read_reg(6'd8, d);  chk(d === 0, "R10", "status after reset", d, 0);
        read_reg(6'd10, d); chk(d === 0, "R10", "mask after reset", d, 0);
        read_reg(6'd0, d);  chk(d === 0, "R10", "mode after reset", d, 0);
        read_reg(6'd1, d);  chk(d === 0, "R10", "line clocks after reset", d, 0);
        // Counters must stay at pixel 0 while the lengths are zero
        write_reg(6'd16, {16'd1, 16'd0});
        for (int i = 0; i < 4; i++) begin
            chk(hsync[0] === 1'b1, "R1", "idle counter held at pixel 0", hsync[0], 1);
            step(1);
        end
    endtask

    task automatic test_sweep();
        logic [31:0] d;
        program_all();
        write_reg(6'd12, 32'd3);
        write_reg(6'd3, 32'd1);
        for (int t = 0; t < FRAME2; t++) begin
            check_outputs();
            if (t == 0)
                chk(active === 1'b0, "R1", "top field first after restart", active, 0);
            if (t == FIELD)
                chk(active === 1'b1, "R1", "bottom field after half-line wrap", active, 1);
            if (t > 0) begin
                read_reg(6'd8, d);
                chk(d === ((t <= FIELD) ? 32'd2 : 32'd3), "R5", "status during frame",
                    d, (t <= FIELD) ? 2 : 3);
                chk(irq === 1'b1, "R7", "irq with mask set", irq, 1);
            end
            if (t == 0) begin
                // Clear both bits on the edge that registers the top event
                reg_wr = 1'b1; reg_addr = 6'd9; reg_wdata = 32'd3;
            end
            @(negedge clk);
            reg_wr = 1'b0;
        end
    endtask

    task automatic test_clear_mask();
        logic [31:0] d;
        write_reg(6'd9, 32'd1);
        read_reg(6'd8, d); chk(d === 32'd2, "R6", "clear only bit 0", d, 2);
        write_reg(6'd11, 32'd2);
        read_reg(6'd10, d); chk(d === 32'd1, "R7", "mask clear bit 1 only", d, 1);
        chk(irq === 1'b0, "R7", "irq masked off", irq, 0);
        while (tpos % FRAME2 != FIELD) step(1);
        chk(irq === 1'b0, "R5", "irq before bottom event edge", irq, 0);
        step(1);
        chk(irq === 1'b1, "R5", "irq after bottom event edge", irq, 1);
        read_reg(6'd8, d); chk(d === 32'd3, "R5", "bottom bit set", d, 3);
        write_reg(6'd12, 32'd2);
        read_reg(6'd10, d); chk(d === 32'd3, "R7", "mask set bit 1 only", d, 3);
    endtask

    task automatic test_restart();
        write_reg(6'd3, 32'd0);
        for (int i = 0; i < 3; i++) begin check_outputs(); step(1); end
        while (tpos % CLKS != 6) step(1);
        write_reg(6'd3, 32'd1);
        chk(tpos == 0, "R8", "bench position after restart", tpos, 0);
        for (int i = 0; i < 12; i++) begin check_outputs(); step(1); end
    endtask

    task automatic test_slave();
        logic [31:0] d;
        while (tpos % CLKS != 3) step(1);
        ext_sync = 1'b1; step(1); ext_sync = 1'b0;
        for (int i = 0; i < 4; i++) begin check_outputs(); step(1); end
        write_reg(6'd0, 32'd1);
        read_reg(6'd0, d); chk(d === 32'd1, "R9", "mode reads slave", d, 1);
        while (tpos % CLKS != 4) step(1);
        ext_sync = 1'b1; step(1); ext_sync = 1'b0;
        chk(tpos == 0, "R9", "bench position after ext sync", tpos, 0);
        for (int i = 0; i < 14; i++) begin check_outputs(); step(1); end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_sweep();
        test_clear_mask();
        test_restart();
        test_slave();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule